// File: doc/BRIEF.md
# ADC Serial Command Port Controller

This block is the digital serial front end of a multi-channel converter. A host drives chip select, serial clock and serial data in; the block returns data on a serial data out line with a separate output enable that models a high-impedance pin. The host sends an 8-bit command byte. The command either writes one of the held 24-bit registers from SDI or shifts one out on SDO. The held registers are a per-setup offset word, a per-setup gain word and one configuration word. A conversion command puts the port into continuous read mode. In that mode every frame opens with a control byte and then shifts out one 24-bit word popped from an internal conversion FIFO. A two-byte sync pattern brings the port back to waiting for a command.

All port lines are oversampled by the system clock through a short synchroniser. The serial clock is reduced to rise and fall pulses. SDI is taken on the rising edge and SDO moves on the falling edge. Every transfer is MSB first.

The controller is one state machine:
- `ST_CMD` collects a command byte.
- `ST_WRITE` collects 24 data bits.
- `ST_READ` shifts a register out.
- `ST_SYNC` waits for the closing sync byte.
- `ST_CONT_CTRL` collects a continuous-mode control byte.
- `ST_CONT_DATA` shifts out a word and then returns to `ST_CONT_CTRL`.
- `ST_CONT_LAST` shifts out the final word and then returns to `ST_CMD`.

These are the transitions:
- `ST_CMD` goes to `ST_SYNC` on 0xFF, to `ST_CONT_CTRL` on a conversion command, and to `ST_READ` or `ST_WRITE` on a register command. Any other byte leaves it in `ST_CMD`.
- `ST_SYNC` stays on 0xFF and goes to `ST_CMD` on any other byte.
- `ST_CONT_CTRL` goes to `ST_CONT_LAST` on 0xFF and to `ST_CONT_DATA` on any other byte.
- `ST_WRITE` and `ST_READ` return to `ST_CMD` after 24 bits.
- Raising chip select sends the two continuous data states back to `ST_CONT_CTRL` and `ST_CONT_LAST` to `ST_CMD`. Every other state except a byte-aligned `ST_SYNC` also goes to `ST_CMD`.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset SDO is disabled, the underflow flag is low, no FIFO pop occurs, every offset word reads 0x000000, every gain word reads 0x400000 and the configuration word reads 0x000000.
- R2: A command byte is taken MSB first on rising SCLK edges. Bit 7 is the conversion flag and bits 6:4 are the setup pointer. Bit 3 is the direction, where 1 means read. Bits 2:0 select the register when the flag is 0: 000 is offset[pointer], 001 is gain[pointer] and 010 is configuration.
- R3: A register command with direction 0 takes the next 24 SDI bits MSB first and updates the selected register only when the 24th bit arrives.
- R4: A register command with direction 1 presents the selected register on SDO, MSB first. The first bit appears at the falling edge after the 8th command bit, and SDO changes only on falling SCLK edges.
- R5: A command with flag 0 and selector 011 to 111, or with flag 1 and a selector other than 000 (except 0xFF), is ignored. It has no data phase, SDO stays disabled and the next byte is a command.
- R6: Raising chip select in the middle of a transfer discards the partial bits, changes no register and restarts bit counting at zero.
- R7: SDO is enabled only while chip select is low and a read shift is in progress.
- R8: Command byte 0xFF enters sync wait. Further 0xFF bytes keep it there. Any other byte, such as the closing 0xFE, is discarded and the port then waits for a new command.
- R9: A command with flag 1 and selector 000 enters continuous read mode.
- R10: In continuous mode each frame starts with an 8-bit control byte. Any value other than 0xFF keeps the mode, pops one FIFO word at the end of the control byte and shifts it out in the next 24 clocks.
- R11: Control byte 0xFF shifts out one final word in the next 24 clocks, after which the port waits for a command.
- R12: If the FIFO is empty when a word is due, 24 zeros are shifted out, nothing is popped and a sticky underflow flag is set that stays set until reset.
- R13: The FIFO pop is a single-cycle pulse and is issued only when the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out, low while disabled |
| sdo_oe | output | 1 | SDO drive enable; low means high impedance |
| fifo_data | input | DATA_W | Head word of the conversion FIFO |
| fifo_empty | input | 1 | Conversion FIFO holds no word |
| fifo_pop | output | 1 | Remove the head word of the FIFO |
| underflow | output | 1 | Sticky flag: a word was due while the FIFO was empty |

## Verification
A bit counter that slips by even one position shows up at the next read: the returned word comes back shifted, or a command lands in the wrong state and the data phase is missing. SDO enable then stays low for the whole frame. A wrong state after an abort, a sync pair or a continuous-mode exit appears in the very next frame, as missing or extra SDO activity or as a wrong FIFO pop count. A wrong register write appears only when that register is read back, so each write is followed by a read of the same and of a neighbouring register.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_SYNC,
        ST_CONT_CTRL,
        ST_CONT_DATA,
        ST_CONT_LAST
    } port_state_e;

    localparam int BYTE_W = 8;

    // register selector field, bits 2:0 of a command with flag 0
    localparam logic [2:0] SEL_OFFSET = 3'b000;
    localparam logic [2:0] SEL_GAIN   = 3'b001;
    localparam logic [2:0] SEL_CONFIG = 3'b010;
    // selector value that starts continuous reads when the flag is 1
    localparam logic [2:0] SEL_CONVERT = 3'b000;

    localparam logic [7:0] BYTE_SYNC_HEAD = 8'hFF;
    localparam logic [7:0] BYTE_CONT_EXIT = 8'hFF;

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_active,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    // each stage holds {cs_n, sclk, sdi}
    logic [2:0] pipe_q [STAGES];
    logic       sclk_prev_q;
    logic       sclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= 3'b110;
            sclk_prev_q <= 1'b1;
        end else begin
            pipe_q[0] <= {cs_n, sclk, sdi};
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            sclk_prev_q <= pipe_q[STAGES-1][1];
        end
    end

    assign cs_active = ~pipe_q[STAGES-1][2];
    assign sclk_s    = pipe_q[STAGES-1][1];
    assign sdi_s     = pipe_q[STAGES-1][0];
    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;

endmodule

// File: rtl/adc_port_regs.sv
module adc_port_regs
    import adc_port_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int NUM_SETUPS = 8,
    parameter int PTR_W      = 3,
    parameter logic [DATA_W-1:0] GAIN_RESET = DATA_W'(1) << (DATA_W - 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] offset_vec [NUM_SETUPS];
    logic [DATA_W-1:0] gain_vec   [NUM_SETUPS];
    logic [DATA_W-1:0] config_q;
    logic              rd_in_range;

    for (genvar g = 0; g < NUM_SETUPS; g++) begin : g_setup
        logic [DATA_W-1:0] off_q;
        logic [DATA_W-1:0] gn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q <= '0;
                gn_q  <= GAIN_RESET;
            end else if (wr_en && wr_ptr == PTR_W'(g)) begin
                if (wr_sel == SEL_OFFSET) off_q <= wr_data;
                if (wr_sel == SEL_GAIN)   gn_q  <= wr_data;
            end
        end

        assign offset_vec[g] = off_q;
        assign gain_vec[g]   = gn_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               config_q <= '0;
        else if (wr_en && wr_sel == SEL_CONFIG)   config_q <= wr_data;
    end

    assign rd_in_range = 32'(rd_ptr) < NUM_SETUPS;

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_OFFSET: if (rd_in_range) rd_data = offset_vec[rd_ptr];
            SEL_GAIN:   if (rd_in_range) rd_data = gain_vec[rd_ptr];
            SEL_CONFIG: rd_data = config_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int NUM_SETUPS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              underflow
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int PTR_W = 3;

    logic cs_active, sdi_s, sclk_rise, sclk_fall;

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [DATA_W-2:0] rx_q;
    logic [DATA_W-1:0] rx_next, tx_q, rd_data;
    logic [BYTE_W-1:0] rx_byte;
    logic [PTR_W-1:0]  cmd_ptr_q;
    logic [2:0]        cmd_sel_q;
    logic              sdo_q, underflow_q;
    logic              short_phase, last_bit, phase_done, shifting;
    logic              load_reg, start_cont, wr_en;

    adc_port_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_active (cs_active),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    adc_port_regs #(
        .DATA_W     (DATA_W),
        .NUM_SETUPS (NUM_SETUPS),
        .PTR_W      (PTR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (cmd_sel_q),
        .wr_ptr  (cmd_ptr_q),
        .wr_data (rx_next),
        .rd_sel  (rx_byte[2:0]),
        .rd_ptr  (rx_byte[6:4]),
        .rd_data (rd_data)
    );

    assign rx_next     = {rx_q, sdi_s};
    assign rx_byte     = rx_next[BYTE_W-1:0];
    assign short_phase = state_q inside {ST_CMD, ST_SYNC, ST_CONT_CTRL};
    assign last_bit    = short_phase ? (bitcnt_q == CNT_W'(BYTE_W - 1))
                                     : (bitcnt_q == CNT_W'(DATA_W - 1));
    assign phase_done  = cs_active && sclk_rise && last_bit;
    assign shifting    = state_q inside {ST_READ, ST_CONT_DATA, ST_CONT_LAST};

    // next state and phase-end actions
    always_comb begin
        state_d    = state_q;
        load_reg   = 1'b0;
        start_cont = 1'b0;
        wr_en      = 1'b0;
        if (!cs_active) begin
            unique case (state_q)
                ST_SYNC:                    state_d = (bitcnt_q == '0) ? ST_SYNC : ST_CMD;
                ST_CONT_CTRL, ST_CONT_DATA: state_d = ST_CONT_CTRL;
                default:                    state_d = ST_CMD;
            endcase
        end else if (phase_done) begin
            unique case (state_q)
                ST_CMD: begin
                    if (rx_byte == BYTE_SYNC_HEAD) begin
                        state_d = ST_SYNC;
                    end else if (rx_byte[7]) begin
                        if (rx_byte[2:0] == SEL_CONVERT) state_d = ST_CONT_CTRL;
                    end else if (rx_byte[2:0] inside {SEL_OFFSET, SEL_GAIN, SEL_CONFIG}) begin
                        if (rx_byte[3]) begin
                            state_d  = ST_READ;
                            load_reg = 1'b1;
                        end else begin
                            state_d  = ST_WRITE;
                        end
                    end
                end
                ST_SYNC:  state_d = (rx_byte == BYTE_SYNC_HEAD) ? ST_SYNC : ST_CMD;
                ST_WRITE: begin
                    wr_en   = 1'b1;
                    state_d = ST_CMD;
                end
                ST_READ:  state_d = ST_CMD;
                ST_CONT_CTRL: begin
                    start_cont = 1'b1;
                    state_d    = (rx_byte == BYTE_CONT_EXIT) ? ST_CONT_LAST : ST_CONT_DATA;
                end
                ST_CONT_DATA: state_d = ST_CONT_CTRL;
                ST_CONT_LAST: state_d = ST_CMD;
                default:      state_d = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // shift registers, counter and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            cmd_ptr_q   <= '0;
            cmd_sel_q   <= '0;
            sdo_q       <= 1'b0;
            underflow_q <= 1'b0;
        end else begin
            if (!cs_active) begin
                bitcnt_q <= '0;
            end else if (sclk_rise) begin
                bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
                rx_q     <= rx_next[DATA_W-2:0];
            end
            if (phase_done && state_q == ST_CMD) begin
                cmd_ptr_q <= rx_byte[6:4];
                cmd_sel_q <= rx_byte[2:0];
            end
            if (load_reg) begin
                tx_q <= rd_data;
            end else if (start_cont) begin
                tx_q <= fifo_empty ? '0 : fifo_data;
            end else if (shifting && cs_active && sclk_fall) begin
                sdo_q <= tx_q[DATA_W-1];
                tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            end
            if (start_cont && fifo_empty) underflow_q <= 1'b1;
        end
    end

    always_comb begin
        sdo_oe    = cs_active && shifting;
        sdo       = sdo_oe & sdo_q;
        fifo_pop  = start_cont & ~fifo_empty;
        underflow = underflow_q;
    end

endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic underflow,
    input logic sclk_fall
);
    // R7: chip select held high through the synchroniser keeps SDO off
    a_r7_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    // R4: SDO moves only after a falling serial clock edge
    a_r4_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo));

    // R12: underflow is sticky
    a_r12_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(underflow) |-> underflow);

    // R12: underflow only rises after the FIFO was empty
    a_r12_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(fifo_empty));

    // R13: no pop from an empty FIFO
    a_r13_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R13: pop is a single-cycle pulse
    a_r13_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

endmodule

bind adc_cmd_port adc_cmd_port_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .underflow  (underflow),
    .sclk_fall  (sclk_fall)
);

// File: tb/test_adc_cmd_port.sv
`timescale 1ns/1ps
module test_adc_cmd_port;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, fifo_pop, underflow, fifo_empty;
    logic [23:0] fifo_data;

    logic [23:0] fmem [8];
    logic [3:0]  fwr = '0;
    logic [3:0]  frd = '0;
    int pops = 0, pop_bad = 0, total = 0, bad = 0;
    bit done = 1'b0;

    assign fifo_empty = (fwr == frd);
    assign fifo_data  = fmem[frd[2:0]];

    always #2.5 clk = ~clk;

    adc_cmd_port i_adc_cmd_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .underflow(underflow)
    );

    always @(posedge clk) begin
        if (rst_n && fifo_pop) begin
            pops++;
            if (fwr == frd) pop_bad++;
            frd <= frd + 4'd1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [23:0] w);
        fmem[fwr[2:0]] = w;
        fwr = fwr + 4'd1;
    endtask

    task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout,
                        output int oe_n, output int hi_chg);
        dout = '0; oe_n = 0; hi_chg = 0;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            sdi  = din[i];
            wait_clk(HALF);
            dout = {dout[30:0], sdo};
            if (sdo_oe) oe_n++;
            sclk = 1'b1;
            wait_clk(HALF);
            if (sdo_oe && sdo !== dout[0]) hi_chg++;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic frame_end();
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [23:0] data);
        logic [31:0] d; int o, h;
        frame_start();
        xfer(8, {24'd0, cmd}, d, o, h);
        xfer(24, {8'd0, data}, d, o, h);
        frame_end();
    endtask

    task automatic do_read(input logic [7:0] cmd, output logic [31:0] data,
                           output int oe_n, output int hi_chg);
        logic [31:0] d; int o, h;
        frame_start();
        xfer(8, {24'd0, cmd}, d, o, h);
        xfer(24, 32'd0, data, oe_n, hi_chg);
        frame_end();
    endtask

    task automatic t_reset();
        logic [31:0] d; int o, h;
        chk("R1 sdo_oe after reset", sdo_oe, 0);
        chk("R1 underflow after reset", underflow, 0);
        chk("R1 fifo_pop after reset", fifo_pop, 0);
        do_read(8'h29, d, o, h);
        chk("R1 gain[2] reset value", d, 32'h400000);
        do_read(8'h08, d, o, h);
        chk("R1 offset[0] reset value", d, 32'h0);
        do_read(8'h0A, d, o, h);
        chk("R1 config reset value", d, 32'h0);
    endtask

    task automatic t_write_read();
        logic [31:0] d; int o, h;
        do_write(8'h30, 24'hA5C35A);
        do_read(8'h38, d, o, h);
        chk("R3 offset[3] write/read", d, 32'hA5C35A);
        chk("R4 sdo_oe cycles in read", o, 24);
        chk("R4 sdo steady while sclk high", h, 0);
        do_write(8'h51, 24'h123456);
        do_read(8'h59, d, o, h);
        chk("R2 gain[5] write/read", d, 32'h123456);
        do_read(8'h48, d, o, h);
        chk("R2 offset[4] untouched by other pointer", d, 32'h0);
        do_read(8'h49, d, o, h);
        chk("R2 gain[4] untouched by other pointer", d, 32'h400000);
        do_write(8'h02, 24'hFEDCBA);
        do_read(8'h0A, d, o, h);
        chk("R3 config write/read", d, 32'hFEDCBA);
    endtask

    task automatic t_ignored();
        logic [31:0] d; int o, o2, h;
        frame_start();
        xfer(8, 32'h0B, d, o, h);
        xfer(8, 32'h9C, d, o2, h);
        chk("R5 no SDO after ignored commands", o + o2, 0);
        xfer(8, 32'h59, d, o, h);
        xfer(24, 32'd0, d, o, h);
        frame_end();
        chk("R5 next byte taken as command", d, 32'h123456);
    endtask

    task automatic t_abort();
        logic [31:0] d; int o, h;
        frame_start();
        xfer(8, 32'h30, d, o, h);
        xfer(10, 32'h3FF, d, o, h);
        frame_end();
        do_read(8'h38, d, o, h);
        chk("R6 aborted write leaves offset[3]", d, 32'hA5C35A);
        frame_start();
        xfer(5, 32'h1F, d, o, h);
        frame_end();
        do_read(8'h0A, d, o, h);
        chk("R6 counter restarts after mid-byte abort", d, 32'hFEDCBA);
        frame_start();
        xfer(8, 32'h38, d, o, h);
        xfer(5, 32'h0, d, o, h);
        chk("R7 sdo_oe high during read", sdo_oe, 1);
        frame_end();
        chk("R7 sdo_oe low after deselect", sdo_oe, 0);
        do_read(8'h59, d, o, h);
        chk("R6 read after aborted read", d, 32'h123456);
    endtask

    task automatic t_sync();
        logic [31:0] d; int o, o2, o3, h;
        frame_start();
        xfer(8, 32'hFF, d, o, h);
        xfer(8, 32'h0A, d, o2, h);
        chk("R8 byte after sync head discarded", o + o2, 0);
        xfer(8, 32'h0A, d, o, h);
        xfer(24, 32'd0, d, o, h);
        frame_end();
        chk("R8 command accepted after sync", d, 32'hFEDCBA);
        frame_start();
        xfer(8, 32'hFF, d, o, h);
        xfer(8, 32'hFF, d, o2, h);
        xfer(8, 32'hFE, d, o3, h);
        chk("R8 no SDO during sync pair", o + o2 + o3, 0);
        xfer(8, 32'h38, d, o, h);
        xfer(24, 32'd0, d, o, h);
        frame_end();
        chk("R8 read after FF FF FE", d, 32'hA5C35A);
    endtask

    task automatic t_cont();
        logic [31:0] d; int o, o2, h, p0;
        push(24'hC0FFEE); push(24'h0BEEF1); push(24'h7A5A5A);
        p0 = pops;
        frame_start();
        xfer(8, 32'h80, d, o, h);
        xfer(8, 32'h00, d, o2, h);
        chk("R9 no SDO during conversion command and control", o + o2, 0);
        xfer(24, 32'd0, d, o, h);
        chk("R10 first continuous word", d, 32'hC0FFEE);
        chk("R10 sdo_oe cycles in word", o, 24);
        xfer(8, 32'h5A, d, o, h);
        xfer(24, 32'd0, d, o, h);
        chk("R10 non-FF control keeps mode", d, 32'h0BEEF1);
        xfer(8, 32'hFF, d, o, h);
        xfer(24, 32'd0, d, o, h);
        chk("R11 final word after FF", d, 32'h7A5A5A);
        xfer(8, 32'h0A, d, o, h);
        xfer(24, 32'd0, d, o, h);
        frame_end();
        chk("R11 command mode after exit", d, 32'hFEDCBA);
        chk("R13 pops in continuous run", pops - p0, 3);
        chk("R13 no pop from empty", pop_bad, 0);
        chk("R12 no underflow with data", underflow, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] d; int o, h, p0;
        p0 = pops;
        frame_start();
        xfer(8, 32'h80, d, o, h);
        xfer(8, 32'h00, d, o, h);
        xfer(24, 32'd0, d, o, h);
        chk("R12 zeros on empty FIFO", d, 32'h0);
        chk("R12 underflow raised", underflow, 1);
        xfer(8, 32'hFF, d, o, h);
        xfer(24, 32'd0, d, o, h);
        chk("R12 zeros on final empty word", d, 32'h0);
        frame_end();
        chk("R12 no pop while empty", pops - p0, 0);
        do_read(8'h59, d, o, h);
        chk("R11 command after empty exit", d, 32'h123456);
        chk("R12 underflow still set", underflow, 1);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_read();
        t_ignored();
        t_abort();
        t_sync();
        t_cont();
        t_underflow();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule